// File: doc/BRIEF.md
# Floating-Point Set-on-Compare Unit

This block takes two floating-point operands, compares them under one of six relations, and records the outcome as a single persistent status bit. Each operation selects its own precision. In single precision the low 32 bits of each operand input hold an IEEE-754 single. In double precision all 64 bits hold an IEEE-754 double, which in the surrounding machine comes from an even/odd register pair named by its even register.

A pipeline drives both operands, the precision select and a 3-bit relation code, and strobes `valid` for one cycle. On the next clock edge the status flag takes the new outcome and `done` pulses. Between operations the flag keeps its value, so later logic can test it whenever it needs to. Signed zeros are treated as equal. A NaN in either operand makes the pair unordered. Infinities are ordered by their sign.

Top module: `fp_cmp_unit`

## Requirements
- R1: The relation code `cond` selects the test: 0 less-than, 1 greater-than, 2 equal, 3 less-or-equal, 4 greater-or-equal, 5 not-equal. Each test is applied as op_a relation op_b.
- R2: When `valid` is high and `cond` is 0 to 5, the flag becomes 1 if the selected relation holds for the operands and 0 if it does not.
- R3: When `dbl_sel` is 1, each operand is a 64-bit double: sign in bit 63, exponent in bits 62:52, fraction in bits 51:0.
- R4: When `dbl_sel` is 0, each operand is a single taken from bits 31:0: sign in bit 31, exponent in bits 30:23, fraction in bits 22:0. Bits 63:32 have no effect on the result.
- R5: Positive zero and negative zero compare as equal in both precisions.
- R6: An operand is a NaN when its exponent is all ones and its fraction is nonzero. If either operand is a NaN, relations 0 to 4 give 0 and relation 5 gives 1.
- R7: An infinity (exponent all ones, fraction zero) is ordered by its sign. Negative infinity is below every finite value, and positive infinity is above every finite value. Two infinities of the same sign are equal.
- R8: The flag changes only on the clock edge that follows a cycle with `valid` high. `done` is high for exactly the cycle after each `valid` cycle and low otherwise.
- R9: Codes 6 and 7 leave the flag unchanged, and `done` still pulses.
- R10: While reset is active, and immediately after it, `flag` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 64 | First operand (left-hand side of the relation) |
| op_b | input | 64 | Second operand (right-hand side of the relation) |
| dbl_sel | input | 1 | 1 selects double precision, 0 selects single precision |
| cond | input | 3 | Relation code |
| valid | input | 1 | Operation strobe, one cycle per compare |
| flag | output | 1 | Registered status flag |
| done | output | 1 | One-cycle pulse after each strobe |

## Verification
The assertions assume that `op_a`, `op_b`, `dbl_sel` and `cond` are stable and meaningful in every cycle where `valid` is high. They place no requirement on these inputs when `valid` is low. The bench changes every input only on the falling clock edge. It also drives random operands, random codes and random precisions during idle cycles, so the flag is shown to hold whatever sits on the inputs. Codes 6 and 7 are deliberately part of the random mix, to confirm that the flag is left alone under those codes.

// File: rtl/fpcmp_pkg.sv
`timescale 1ns/1ps
package fpcmp_pkg;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;
  localparam int SP_W      = 1 + SP_EXP_W + SP_FRAC_W;
  localparam int DP_W      = 1 + DP_EXP_W + DP_FRAC_W;
  localparam int MAG_W     = DP_W - 1;
  localparam int KEY_W     = DP_W + 1;
  localparam int COND_W    = 3;
  localparam int N_OPND    = 2;

  typedef enum logic [COND_W-1:0] {
    REL_LT = 3'd0,
    REL_GT = 3'd1,
    REL_EQ = 3'd2,
    REL_LE = 3'd3,
    REL_GE = 3'd4,
    REL_NE = 3'd5
  } rel_e;

  typedef struct packed {
    logic             nan;
    logic             zero;
    logic [KEY_W-1:0] key;
  } fp_class_t;

  // Exponent all ones with a nonzero fraction
  function automatic logic is_nan_f(input logic [DP_W-1:0] bits, input logic dbl);
    if (dbl) return (&bits[DP_W-2 -: DP_EXP_W]) && (|bits[DP_FRAC_W-1:0]);
    else     return (&bits[SP_W-2 -: SP_EXP_W]) && (|bits[SP_FRAC_W-1:0]);
  endfunction

  function automatic logic sign_f(input logic [DP_W-1:0] bits, input logic dbl);
    return dbl ? bits[DP_W-1] : bits[SP_W-1];
  endfunction

  // Magnitude without sign, zero-extended to the double width
  function automatic logic [MAG_W-1:0] magnitude_f(input logic [DP_W-1:0] bits, input logic dbl);
    return dbl ? bits[MAG_W-1:0] : MAG_W'(bits[SP_W-2:0]);
  endfunction

  // Signed total-order key: both zeros map to 0
  function automatic logic [KEY_W-1:0] order_key_f(input logic [MAG_W-1:0] mag, input logic sgn);
    logic [KEY_W-1:0] k;
    k = {2'b00, mag};
    return sgn ? (~k + 1'b1) : k;
  endfunction

  function automatic logic rel_holds_f(input logic [COND_W-1:0] c, input logic lt,
                                       input logic eq, input logic gt);
    case (c)
      REL_LT:  return lt;
      REL_GT:  return gt;
      REL_EQ:  return eq;
      REL_LE:  return lt | eq;
      REL_GE:  return gt | eq;
      REL_NE:  return ~eq;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic cond_legal_f(input logic [COND_W-1:0] c);
    return c <= REL_NE;
  endfunction
endpackage

// File: rtl/fpcmp_classify.sv
`timescale 1ns/1ps
module fpcmp_classify
  import fpcmp_pkg::*;
(
  input  logic [DP_W-1:0] raw,
  input  logic            dbl,
  output fp_class_t       cls
);
  logic [MAG_W-1:0] mag;
  logic             sgn;

  assign mag      = magnitude_f(raw, dbl);
  assign sgn      = sign_f(raw, dbl);
  assign cls.nan  = is_nan_f(raw, dbl);
  assign cls.zero = (mag == '0);
  assign cls.key  = order_key_f(mag, sgn);
endmodule

// File: rtl/fpcmp_relate.sv
`timescale 1ns/1ps
module fpcmp_relate
  import fpcmp_pkg::*;
(
  input  fp_class_t a,
  input  fp_class_t b,
  output logic      lt,
  output logic      eq,
  output logic      gt,
  output logic      unord
);
  logic key_lt, key_eq;

  assign key_lt = $signed(a.key) < $signed(b.key);
  assign key_eq = (a.key == b.key);
  assign unord  = a.nan | b.nan;
  assign lt     = ~unord & key_lt;
  assign eq     = ~unord & key_eq;
  assign gt     = ~unord & ~key_lt & ~key_eq;
endmodule

// File: rtl/fpcmp_status.sv
`timescale 1ns/1ps
module fpcmp_status
  import fpcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [COND_W-1:0] cond,
  input  logic              lt,
  input  logic              eq,
  input  logic              gt,
  output logic              cond_ok,
  output logic              rel_true,
  output logic              flag,
  output logic              done
);
  assign cond_ok  = cond_legal_f(cond);
  assign rel_true = rel_holds_f(cond, lt, eq, gt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= valid;
      if (valid && cond_ok) flag <= rel_true;
    end
  end
endmodule

// File: rtl/fp_cmp_unit.sv
`timescale 1ns/1ps
module fp_cmp_unit
  import fpcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DP_W-1:0]   op_a,
  input  logic [DP_W-1:0]   op_b,
  input  logic              dbl_sel,
  input  logic [COND_W-1:0] cond,
  input  logic              valid,
  output logic              flag,
  output logic              done
);
  logic [DP_W-1:0] opnd [N_OPND];
  fp_class_t       cls  [N_OPND];

  // Named internal events, observed by the checker
  logic cmp_lt, cmp_eq, cmp_gt, cmp_unord;
  logic zero_a, zero_b;
  logic cond_ok, rel_true;

  assign opnd[0] = op_a;
  assign opnd[1] = op_b;

  for (genvar i = 0; i < N_OPND; i++) begin : g_cls
    fpcmp_classify u_cls (
      .raw (opnd[i]),
      .dbl (dbl_sel),
      .cls (cls[i])
    );
  end

  assign zero_a = cls[0].zero;
  assign zero_b = cls[1].zero;

  fpcmp_relate u_rel (
    .a     (cls[0]),
    .b     (cls[1]),
    .lt    (cmp_lt),
    .eq    (cmp_eq),
    .gt    (cmp_gt),
    .unord (cmp_unord)
  );

  fpcmp_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (valid),
    .cond     (cond),
    .lt       (cmp_lt),
    .eq       (cmp_eq),
    .gt       (cmp_gt),
    .cond_ok  (cond_ok),
    .rel_true (rel_true),
    .flag     (flag),
    .done     (done)
  );
endmodule

// File: rtl/fpcmp_sva.sv
`timescale 1ns/1ps
module fpcmp_sva
  import fpcmp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              valid,
  input logic [COND_W-1:0] cond,
  input logic              flag,
  input logic              done,
  input logic              cmp_lt,
  input logic              cmp_eq,
  input logic              cmp_gt,
  input logic              cmp_unord,
  input logic              zero_a,
  input logic              zero_b,
  input logic              cond_ok,
  input logic              rel_true
);
  // R8
  done_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> done);
  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> !done);
  // R8
  flag_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(flag));
  // R9
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cond > REL_NE) |=> $stable(flag));
  // R6
  unord_ne_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cmp_unord && cond == REL_NE) |=> flag);
  // R6
  unord_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cmp_unord && cond < REL_NE) |=> !flag);
  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $countones({cmp_lt, cmp_eq, cmp_gt, cmp_unord}) == 1);
  // R5
  zero_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && zero_a && zero_b) |-> cmp_eq);
  // R2
  flag_takes_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cond_ok) |=> flag == $past(rel_true));
endmodule

bind fp_cmp_unit fpcmp_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid     (valid),
  .cond      (cond),
  .flag      (flag),
  .done      (done),
  .cmp_lt    (cmp_lt),
  .cmp_eq    (cmp_eq),
  .cmp_gt    (cmp_gt),
  .cmp_unord (cmp_unord),
  .zero_a    (zero_a),
  .zero_b    (zero_b),
  .cond_ok   (cond_ok),
  .rel_true  (rel_true)
);

// File: tb/fp_cmp_unit_tb.sv
`timescale 1ns/1ps
module fp_cmp_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        dbl_sel = 1'b0;
  logic [2:0]  cond = '0;
  logic        valid = 1'b0;
  logic        flag, done;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R10";
  bit    exp_flag = 1'b0;
  bit    exp_done = 1'b0;

  always #4 clk = ~clk;

  fp_cmp_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .dbl_sel(dbl_sel),
    .cond(cond), .valid(valid), .flag(flag), .done(done)
  );

  // Returns -1 (a<b), 0 (equal), 1 (a>b), 2 (unordered)
  function automatic int ref_order(input logic [63:0] a, input logic [63:0] b, input bit d);
    bit sa, sb; longint unsigned ea, eb, fa, fb, emax, ma, mb;
    if (d) begin
      sa = a[63]; sb = b[63]; ea = a[62:52]; eb = b[62:52];
      fa = a[51:0]; fb = b[51:0]; emax = 2047;
    end else begin
      sa = a[31]; sb = b[31]; ea = a[30:23]; eb = b[30:23];
      fa = a[22:0]; fb = b[22:0]; emax = 255;
    end
    if ((ea == emax && fa != 0) || (eb == emax && fb != 0)) return 2;
    if (ea == 0 && fa == 0 && eb == 0 && fb == 0) return 0;
    if (sa != sb) return sa ? -1 : 1;
    ma = d ? (ea << 52) | fa : (ea << 23) | fa;
    mb = d ? (eb << 52) | fb : (eb << 23) | fb;
    if (ma == mb) return 0;
    if (ma < mb) return sa ? 1 : -1;
    return sa ? -1 : 1;
  endfunction

  function automatic bit ref_rel(input int o, input int c);
    case (c)
      0: return o == -1;
      1: return o == 1;
      2: return o == 0;
      3: return o == -1 || o == 0;
      4: return o == 1 || o == 0;
      default: return o != 0;
    endcase
  endfunction

  // Cycle reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_flag = 1'b0;
      exp_done = 1'b0;
    end else begin
      exp_done = valid;
      if (valid && cond < 3'd6)
        exp_flag = ref_rel(ref_order(op_a, op_b, dbl_sel), int'(cond));
    end
  end

  task automatic compare_now();
    n_chk++;
    if (flag !== exp_flag || done !== exp_done) begin
      n_fail++;
      $display("FAIL %s: flag=%0b done=%0b expected flag=%0b done=%0b",
               cur_req, flag, done, exp_flag, exp_done);
    end
  endtask

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input bit d,
                       input logic [2:0] c, input bit v, input string r);
    @(negedge clk);
    compare_now();
    op_a = a; op_b = b; dbl_sel = d; cond = c; valid = v; cur_req = r;
  endtask

  task automatic all_rel(input logic [63:0] a, input logic [63:0] b, input bit d,
                         input string r);
    for (int c = 0; c < 6; c++) drive(a, b, d, 3'(c), 1'b1, r);
  endtask

  localparam logic [63:0] S_ONE = 64'h3F800000, S_TWO = 64'h40000000,
    S_MONE = 64'hBF800000, S_PINF = 64'h7F800000, S_NINF = 64'hFF800000,
    S_NAN = 64'h7FC00000, S_NZERO = 64'h80000000, S_MAX = 64'h7F7FFFFF,
    S_DEN = 64'h00000001, S_SNAN = 64'hFF800001;
  localparam logic [63:0] D_ONE = 64'h3FF0000000000000,
    D_BELOW = 64'h3FEFFFFF00000000, D_MONE = 64'hBFF0000000000000,
    D_PINF = 64'h7FF0000000000000, D_NINF = 64'hFFF0000000000000,
    D_NAN = 64'h7FF8000000000000, D_NZERO = 64'h8000000000000000,
    D_MAX = 64'h7FEFFFFFFFFFFFFF;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    // R10 reset state, with a strobe present during reset
    drive(S_ONE, S_TWO, 0, 3'd0, 1'b1, "R10");
    drive(S_ONE, S_TWO, 0, 3'd0, 1'b1, "R10");
    drive('0, '0, 0, 3'd0, 1'b0, "R10");
    rst_n = 1'b1;
    drive('0, '0, 0, 3'd0, 1'b0, "R10");
    // R1 / R2 ordinary singles
    all_rel(S_ONE, S_TWO, 0, "R1");
    all_rel(S_TWO, S_ONE, 0, "R1");
    all_rel(S_ONE, S_ONE, 0, "R2");
    all_rel(S_MONE, S_ONE, 0, "R2");
    all_rel(S_DEN, '0, 0, "R2");
    // R3 doubles: low halves equal, doubles differ
    all_rel(D_ONE, D_BELOW, 1, "R3");
    all_rel(D_MONE, D_ONE, 1, "R3");
    all_rel(D_MAX, D_ONE, 1, "R3");
    // R4 singles with noise in the upper half
    all_rel(64'hFFFF0000_3F800000, 64'h12345678_40000000, 0, "R4");
    all_rel(64'hDEADBEEF_00000000, 64'h00000000_00000000, 0, "R4");
    all_rel(64'h7FF80000_3F800000, S_ONE, 0, "R4");
    // R5 signed zeros
    all_rel(S_NZERO, '0, 0, "R5");
    all_rel('0, D_NZERO, 1, "R5");
    all_rel(S_NZERO, S_DEN, 0, "R5");
    // R6 NaNs
    all_rel(S_NAN, S_ONE, 0, "R6");
    all_rel(S_ONE, S_SNAN, 0, "R6");
    all_rel(S_NAN, S_NAN, 0, "R6");
    all_rel(D_NAN, D_ONE, 1, "R6");
    // R7 infinities
    all_rel(S_PINF, S_MAX, 0, "R7");
    all_rel(S_NINF, S_MONE, 0, "R7");
    all_rel(S_PINF, S_PINF, 0, "R7");
    all_rel(D_NINF, D_PINF, 1, "R7");
    all_rel(D_PINF, D_MAX, 1, "R7");
    // R8 idle cycles with changing inputs hold the flag
    drive(S_ONE, S_ONE, 0, 3'd2, 1'b1, "R8");
    for (int i = 0; i < 4; i++) drive(S_TWO, S_ONE, 0, 3'd2, 1'b0, "R8");
    drive(S_ONE, S_TWO, 0, 3'd2, 1'b1, "R8");
    for (int i = 0; i < 3; i++) drive(S_ONE, S_ONE, 0, 3'd2, 1'b0, "R8");
    // R9 reserved codes: flag set, then codes 6/7 with a false relation
    drive(S_ONE, S_ONE, 0, 3'd2, 1'b1, "R9");
    drive(S_TWO, S_ONE, 0, 3'd6, 1'b1, "R9");
    drive(S_TWO, S_ONE, 0, 3'd7, 1'b1, "R9");
    drive(S_ONE, S_TWO, 0, 3'd1, 1'b1, "R9");
    drive(S_ONE, S_TWO, 0, 3'd7, 1'b1, "R9");
    drive(S_ONE, S_TWO, 0, 3'd6, 1'b0, "R9");
    // Random mix over all codes and precisions
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] pool [10];
      logic [63:0] a, b;
      bit d;
      d = $urandom_range(0, 1);
      pool = '{S_ONE, S_TWO, S_MONE, S_PINF, S_NINF, S_NAN, S_NZERO, 64'h0,
               d ? D_ONE : S_MAX, d ? D_NAN : S_DEN};
      a = ($urandom_range(0, 2) == 0) ? {$urandom, $urandom} : pool[$urandom_range(0, 9)];
      b = ($urandom_range(0, 2) == 0) ? {$urandom, $urandom} : pool[$urandom_range(0, 9)];
      if ($urandom_range(0, 3) == 0) b = a ^ (64'h1 << $urandom_range(0, 63));
      drive(a, b, d, 3'($urandom_range(0, 7)), bit'($urandom_range(0, 3) != 0), "R2");
    end
    drive('0, '0, 0, 3'd0, 1'b0, "R8");
    drive('0, '0, 0, 3'd0, 1'b0, "R8");
    finish_run();
  end
endmodule